// File: doc/BRIEF.md
# Hart Interrupt Priority Selector

This block decides, once per clock, whether a hart should take an interrupt and which one. It looks at the pending and enable vectors, the delegation mask, the current privilege level, the two global interrupt-enable bits (machine and supervisor) and a debug-active flag. It reports a registered one-cycle take strobe together with a cause word that carries the interrupt flag in its top bit and the chosen index in its low bits. The trap-entry logic samples the strobe and the cause to redirect the hart.

Eligibility is decided in two tiers. The non-delegated (machine-level) interrupts are filtered first. Only when none of them is eligible does the block consider the delegated (supervisor-level) set. Among the eligible bits, the winner is chosen by class rather than by raw index. Platform interrupts (index at or above the machine external index) come first, then external, then software, then timer. Inside a class the lowest index wins.

Top module: `hirq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `take_o` is 0 and `cause_o` is all zeros.
- R2: A non-delegated interrupt is eligible when `priv_i` is below machine level (U=0, S=1), or when `priv_i` is machine level (3) and `mie_i` is 1.
- R3: Delegated interrupts are looked at only when no non-delegated interrupt is eligible. They are eligible when `priv_i` is U (0), or when it is S (1) with `sie_i` set. They are never eligible at machine level (3).
- R4: When `dbg_i` is 1, no interrupt is taken in the following cycle.
- R5: Any eligible bit at index MEXT_IDX (11) or above wins over every eligible bit below 11.
- R6: Below index 11, the external class (bit 9) beats the software class (bits 1 and 3), which beats the timer class (bits 5 and 7).
- R7: Within the winning class, the lowest set index is chosen.
- R8: When an interrupt is selected, `take_o` is 1 one clock later. `cause_o[XLEN-1]` is 1, `cause_o[IDXW-1:0]` holds the index, and all other bits are 0. When no interrupt is selected, `take_o` is 0 and `cause_o` is all zeros.
- R9: Only bits that are both pending and enabled can be selected. Bits 0, 2, 4, 6, 8 and 10 belong to no class and are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NIRQ | Pending interrupt bits |
| en_i | input | NIRQ | Per-interrupt enable bits |
| deleg_i | input | NIRQ | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| dbg_i | input | 1 | Hart is in debug mode |
| take_o | output | 1 | Registered take-interrupt strobe |
| cause_o | output | XLEN | Registered cause: interrupt flag in top bit, index in low bits |

## Verification
The bench targets several corner cases, each matched to the fault it would expose:
- A machine-level software bit competes with a delegated external bit while the hart runs in supervisor mode. A design that merged the tiers before ranking would wrongly pick the external bit.
- A platform bit above 11 competes with the supervisor external bit. A design that ranked by raw index or by class alone would pick 9.
- Delegated bits are presented at machine level with the supervisor enable set. A design that ignored the privilege comparison would take them.
- Unclassed even bits are made pending and enabled. A design without the class mask would report causes 0, 2 or 4.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    localparam int SSIP_B = 1;
    localparam int MSIP_B = 3;
    localparam int STIP_B = 5;
    localparam int MTIP_B = 7;
    localparam int SEIP_B = 9;
    localparam int MEIP_B = 11;

    localparam int NCLASS = 4;
    localparam int MASKW  = 64;

    // class 0 = platform (index >= hi), 1 = external, 2 = software, 3 = timer
    function automatic logic [MASKW-1:0] class_mask(input int c, input int n, input int hi);
        logic [MASKW-1:0] m;
        m = '0;
        unique case (c)
            0: begin
                for (int i = 0; i < MASKW; i++)
                    if (i >= hi && i < n) m[i] = 1'b1;
            end
            1: begin
                m[SEIP_B] = 1'b1;
                m[MEIP_B] = 1'b1;
            end
            2: begin
                m[SSIP_B] = 1'b1;
                m[MSIP_B] = 1'b1;
            end
            default: begin
                m[STIP_B] = 1'b1;
                m[MTIP_B] = 1'b1;
            end
        endcase
        return m;
    endfunction

    function automatic logic [MASKW-1:0] legal_mask(input int n, input int hi);
        logic [MASKW-1:0] m;
        m = '0;
        for (int c = 0; c < NCLASS; c++) m = m | class_mask(c, n, hi);
        return m;
    endfunction

endpackage

// File: rtl/hirq_eligible.sv
module hirq_eligible
    import hirq_pkg::*;
#(
    parameter int NIRQ     = 16,
    parameter int MEXT_IDX = 11
) (
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    output logic [NIRQ-1:0] elig_o
);
    localparam logic [MASKW-1:0] LEGAL_FULL = legal_mask(NIRQ, MEXT_IDX);
    localparam logic [NIRQ-1:0]  LEGAL      = LEGAL_FULL[NIRQ-1:0];

    logic [NIRQ-1:0] active;
    logic [NIRQ-1:0] m_cand;
    logic [NIRQ-1:0] s_cand;
    logic            m_ok;
    logic            s_ok;

    always_comb begin
        active = pend_i & en_i & LEGAL;
        m_cand = active & ~deleg_i;
        s_cand = active & deleg_i;
        m_ok   = (priv_i < PRIV_M) || mie_i;
        s_ok   = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && sie_i);
        if (m_ok && (|m_cand))
            elig_o = m_cand;
        else if (s_ok)
            elig_o = s_cand;
        else
            elig_o = '0;
    end
endmodule

// File: rtl/hirq_ctz.sv
module hirq_ctz #(
    parameter int W  = 16,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = |vec_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--)
            if (vec_i[i]) idx_o = IW'(i);
    end
endmodule

// File: rtl/hirq_class_pick.sv
module hirq_class_pick
    import hirq_pkg::*;
#(
    parameter int NIRQ     = 16,
    parameter int MEXT_IDX = 11,
    parameter int IDXW     = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] elig_i,
    output logic            win_o,
    output logic [IDXW-1:0] idx_o
);
    logic [NCLASS-1:0]           c_hit;
    logic [NCLASS-1:0][IDXW-1:0] c_idx;

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        localparam logic [MASKW-1:0] CM_FULL = class_mask(c, NIRQ, MEXT_IDX);
        localparam logic [NIRQ-1:0]  CM      = CM_FULL[NIRQ-1:0];
        logic [NIRQ-1:0] cvec;
        assign cvec = elig_i & CM;
        hirq_ctz #(.W(NIRQ), .IW(IDXW)) u_ctz (
            .vec_i (cvec),
            .hit_o (c_hit[c]),
            .idx_o (c_idx[c])
        );
    end

    always_comb begin
        win_o = 1'b0;
        idx_o = '0;
        for (int c = NCLASS - 1; c >= 0; c--) begin
            if (c_hit[c]) begin
                win_o = 1'b1;
                idx_o = c_idx[c];
            end
        end
    end
endmodule

// File: rtl/hirq_top.sv
module hirq_top
    import hirq_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NIRQ     = 16,
    parameter int MEXT_IDX = 11
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            dbg_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int IDXW = $clog2(NIRQ);

    logic [NIRQ-1:0] elig;
    logic            win;
    logic [IDXW-1:0] win_idx;
    logic            take_d;
    logic [XLEN-1:0] cause_d;

    hirq_eligible #(.NIRQ(NIRQ), .MEXT_IDX(MEXT_IDX)) u_elig (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .elig_o  (elig)
    );

    hirq_class_pick #(.NIRQ(NIRQ), .MEXT_IDX(MEXT_IDX), .IDXW(IDXW)) u_pick (
        .elig_i (elig),
        .win_o  (win),
        .idx_o  (win_idx)
    );

    always_comb begin
        take_d  = win && !dbg_i;
        cause_d = '0;
        if (take_d) begin
            cause_d[XLEN-1]   = 1'b1;
            cause_d[IDXW-1:0] = win_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            take_o  <= 1'b0;
            cause_o <= '0;
        end else begin
            take_o  <= take_d;
            cause_o <= cause_d;
        end
    end
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk #(
    parameter int XLEN     = 32,
    parameter int NIRQ     = 16,
    parameter int MEXT_IDX = 11
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NIRQ-1:0] pend_i,
    input logic [NIRQ-1:0] en_i,
    input logic [NIRQ-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            dbg_i,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o
);
    localparam int IDXW = $clog2(NIRQ);

    logic [NIRQ-1:0] act_q;
    logic [NIRQ-1:0] deleg_q;
    logic            privm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_q   <= '0;
            deleg_q <= '0;
            privm_q <= 1'b0;
        end else begin
            act_q   <= pend_i & en_i;
            deleg_q <= deleg_i;
            privm_q <= (priv_i == 2'd3);
        end
    end

    // R4
    dbg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_i |=> !take_o);

    // R9
    taken_was_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> act_q[cause_o[IDXW-1:0]]);

    // R9
    nothing_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_i & en_i) == '0) |=> !take_o);

    // R3
    mmode_no_deleg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && privm_q) |-> !deleg_q[cause_o[IDXW-1:0]]);

    // R8
    cause_format_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IDXW] == '0)));

    // R8
    idle_cause_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_o |-> (cause_o == '0));
endmodule

bind hirq_top hirq_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .MEXT_IDX(MEXT_IDX)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .dbg_i   (dbg_i),
    .take_o  (take_o),
    .cause_o (cause_o)
);

// File: tb/hirq_top_tb.sv
`timescale 1ns/1ps
module hirq_top_tb;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] pend = '0, en = '0, deleg = '0;
    logic [1:0]      priv = 2'd3;
    logic            mie = 1'b0, sie = 1'b0, dbg = 1'b0;
    logic            take;
    logic [XLEN-1:0] cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit        exp_take;
    logic [XLEN-1:0] exp_cause;
    string     exp_tag;

    always #2.5 clk = ~clk;

    hirq_top #(.XLEN(XLEN), .NIRQ(NIRQ), .MEXT_IDX(11)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .priv_i(priv), .mie_i(mie), .sie_i(sie), .dbg_i(dbg),
        .take_o(take), .cause_o(cause)
    );

    function automatic int rank(int i);
        if (i >= 11) return 0;
        if (i == 9) return 1;
        if (i == 1 || i == 3) return 2;
        if (i == 5 || i == 7) return 3;
        return -1;
    endfunction

    function automatic int ref_pick(logic [NIRQ-1:0] p, logic [NIRQ-1:0] e,
                                    logic [NIRQ-1:0] d, logic [1:0] pv,
                                    logic mi, logic si, logic db);
        int best = -1;
        int bestr = 99;
        bit m_ok = (pv != 2'd3) || mi;
        bit s_ok = (pv == 2'd0) || (pv == 2'd1 && si);
        if (db) return -1;
        for (int tier = 0; tier < 2; tier++) begin
            if (best < 0) begin
                for (int i = 0; i < NIRQ; i++) begin
                    bit ok = p[i] && e[i] && rank(i) >= 0 &&
                             ((tier == 0) ? (!d[i] && m_ok) : (d[i] && s_ok));
                    if (ok && rank(i) < bestr) begin
                        best = i;
                        bestr = rank(i);
                    end
                end
            end
        end
        return best;
    endfunction

    task automatic compare();
        n_cmp++;
        if (take !== exp_take || cause !== exp_cause) begin
            n_bad++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     exp_tag, take, cause, exp_take, exp_cause);
        end
    endtask

    task automatic step(string tag, logic [NIRQ-1:0] p, logic [NIRQ-1:0] e,
                        logic [NIRQ-1:0] d, logic [1:0] pv,
                        logic mi, logic si, logic db);
        int k;
        @(negedge clk);
        compare();
        pend = p; en = e; deleg = d; priv = pv; mie = mi; sie = si; dbg = db;
        k = ref_pick(p, e, d, pv, mi, si, db);
        exp_tag = tag;
        exp_take = (k >= 0);
        exp_cause = '0;
        if (k >= 0) begin
            exp_cause[XLEN-1] = 1'b1;
            exp_cause[3:0] = 4'(k);
        end
    endtask

    localparam logic [NIRQ-1:0] ALL = '1;

    initial begin
        repeat (3) @(negedge clk);
        exp_take = 0; exp_cause = '0; exp_tag = "R1";
        compare();                          // R1 during reset
        rst_n = 1'b1;
        step("R1", '0, '0, '0, 2'd3, 0, 0, 0);   // R1 first cycle after reset
        // R2
        step("R2", 16'h0080, ALL, '0, 2'd3, 0, 0, 0);
        step("R2", 16'h0080, ALL, '0, 2'd3, 1, 0, 0);
        step("R2", 16'h0080, ALL, '0, 2'd1, 0, 0, 0);
        step("R2", 16'h0008, ALL, '0, 2'd0, 0, 0, 0);
        // R3
        step("R3", 16'h0020, ALL, 16'h0020, 2'd1, 0, 0, 0);
        step("R3", 16'h0020, ALL, 16'h0020, 2'd1, 0, 1, 0);
        step("R3", 16'h0020, ALL, 16'h0020, 2'd0, 0, 0, 0);
        step("R3", 16'h0020, ALL, 16'h0020, 2'd3, 1, 1, 0);
        step("R3", 16'h0208, ALL, 16'h0200, 2'd1, 0, 1, 0);
        step("R3", 16'h0208, ALL, 16'h0200, 2'd3, 0, 1, 0);
        step("R3", 16'h0202, ALL, 16'h0202, 2'd1, 1, 1, 0);
        // R4
        step("R4", 16'h0800, ALL, '0, 2'd0, 1, 1, 1);
        step("R4", 16'h0800, ALL, '0, 2'd0, 1, 1, 0);
        // R5
        step("R5", 16'h2200, ALL, '0, 2'd3, 1, 0, 0);
        step("R5", 16'h1800, ALL, '0, 2'd3, 1, 0, 0);
        step("R5", 16'hC0AA, ALL, '0, 2'd3, 1, 0, 0);
        // R6
        step("R6", 16'h0028, ALL, '0, 2'd3, 1, 0, 0);
        step("R6", 16'h0282, ALL, '0, 2'd3, 1, 0, 0);
        // R7
        step("R7", 16'h000A, ALL, '0, 2'd3, 1, 0, 0);
        step("R7", 16'h00A0, ALL, '0, 2'd3, 1, 0, 0);
        // R9
        step("R9", 16'h0555, ALL, '0, 2'd3, 1, 1, 0);
        step("R9", 16'h0080, 16'hFF7F, '0, 2'd3, 1, 1, 0);
        // R8 back-to-back change and drop
        step("R8", 16'h8000, ALL, '0, 2'd0, 0, 0, 0);
        step("R8", '0, ALL, '0, 2'd0, 0, 0, 0);
        // R2 randomised mix over all rules
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] pv;
            case ($urandom_range(0, 2))
                0: pv = 2'd0;
                1: pv = 2'd1;
                default: pv = 2'd3;
            endcase
            step("R2", 16'($urandom), 16'($urandom), 16'($urandom), pv,
                 1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0));
        end
        step("R8", '0, '0, '0, 2'd3, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule